// File: doc/BRIEF.md
# Burst-of-Four Late-Write Port for a Quad-Data-Rate SRAM

This block is the write half of a quad-data-rate SRAM that has its own write port and moves four words per command. The command and its address are taken on a rising edge of the K clock. The four data words come "late": the first is taken on the next K rising edge, and the other three on the three half-cycle edges after it. Each data beat carries its own set of active-low lane write enables, one per 9-bit lane. The block gathers all four beats, then writes them into an internal word array in a single cycle. The array can be observed only through a registered debug read port.

Both clock phases are modelled with one internal clock at twice the K rate. The `kEdge` input is high on the fast-clock edges that stand for K rising edges and low on the edges that stand for complement rising edges. The system must toggle `kEdge` on every fast edge. One burst fills two K cycles, so a new command can follow the previous one on every other K rising edge. Done that way, the beats of back-to-back bursts run with no gap. A command that lands on the K edge where the previous command's first beat is taken is rejected and reported.

Top module: `qdr_b4_write`

## Requirements
- R1: After reset, every array word reads zero and `protoErr` is low.
- R2: A command is accepted only on an edge with `kEdge` high and `wrSelN` low, and `wrAddr` is captured on that edge. `wrSelN` low on an edge with `kEdge` low starts nothing.
- R3: Beat 0 is `wrData` on the K edge two fast edges after the command. Beats 1, 2 and 3 are taken on the three fast edges that follow. Beat i is written to word `{base[ADDR_W-1:2], base[1:0]+i}`, where the 2-bit sum wraps inside the aligned group of four.
- R4: `wrData` and `laneWrN` on edges that are not one of the four beat edges of an accepted command never change the array.
- R5: `laneWrN[l]` is sampled with each beat. When it is 0, bits `9l+8:9l` of that beat's word are written. When it is 1, those bits keep their old value. With `WIDTH`=36 there are four lanes, 0 to 3.
- R6: A command on the K edge that takes beat 2 of the previous burst is accepted. Its beats follow on the very next edges, and the later burst wins where the two bursts overlap.
- R7: A command on the K edge that takes beat 0 of the previous burst is ignored: no beat is taken for it and no word is written for it. `protoErr` is high for exactly the one cycle after that edge, and it is never high otherwise.
- R8: The array is updated on the fast edge after the beat-3 edge. `dbgData` shows `mem[dbgAddr]` as it stood before each edge, so a read issued on the update edge returns the old word and a read on the following edge returns the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two edges per K period |
| rstN | input | 1 | Active-low synchronous reset |
| kEdge | input | 1 | High when the current edge stands for a K rising edge |
| wrSelN | input | 1 | Active-low write command select |
| wrAddr | input | ADDR_W | Burst base word address |
| wrData | input | WIDTH | Late write data beat |
| laneWrN | input | WIDTH/9 | Active-low per-lane write enables, one per beat |
| dbgAddr | input | ADDR_W | Debug read word address |
| dbgData | output | WIDTH | Registered debug read data |
| protoErr | output | 1 | One-cycle pulse for a rejected command |

## Verification
The bench sweeps every base address, so the wrap of the two low address bits inside an aligned group is exercised. A design that carried the sum into bit 2 would corrupt the neighbouring group, and the full-array comparison would show it. Every one of the 16 lane-mask patterns appears on each beat slot, which catches enables sampled once per command instead of per beat, or lanes that are swapped. Noise data with `wrSelN` pulsed on complement edges, back-to-back chains, and a command placed on the first-beat edge target the remaining corner cases: writes taken outside a burst, a base address clobbered by the next command, and a rejected command that still writes. Reads on the commit edge and on the edge after it pin the commit cycle, so a commit one edge early or one edge late is reported.

// File: rtl/qdrw_pkg.sv
package qdrw_pkg;

  // Strobes from the control FSM to the datapath, valid for the current edge.
  typedef struct packed {
    logic       takeAddr;    // command accepted: capture wrAddr
    logic       startBurst;  // first beat of a pending command
    logic       takeBeat;    // a data beat is taken on this edge
    logic [1:0] beatIdx;     // index of that beat
    logic       loadCommit;  // last beat: move the burst to the commit stage
  } qdrwStrobe_t;

  localparam int LANE_BITS = 9;
  localparam int BEATS     = 4;

endpackage

// File: rtl/qdrw_ctrl.sv
module qdrw_ctrl
  import qdrw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        kEdge,
  input  logic        wrSelN,
  output qdrwStrobe_t strb,
  output logic        protoErr
);

  logic       pending;   // command accepted, first beat not yet taken
  logic       active;    // beats 1..3 still to come
  logic [1:0] beatCnt;   // index of the next beat while active

  logic cmdSeen;
  logic accept;
  logic clash;

  always_comb begin
    cmdSeen         = kEdge && !wrSelN;
    accept          = cmdSeen && !pending;
    clash           = cmdSeen && pending;
    strb.takeAddr   = accept;
    strb.startBurst = pending && kEdge;
    strb.takeBeat   = strb.startBurst || active;
    strb.beatIdx    = strb.startBurst ? 2'd0 : beatCnt;
    strb.loadCommit = strb.takeBeat && (strb.beatIdx == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      active   <= 1'b0;
      beatCnt  <= 2'd0;
      protoErr <= 1'b0;
    end else begin
      pending  <= accept || (pending && !kEdge);
      protoErr <= clash;
      if (strb.takeBeat) begin
        active  <= (strb.beatIdx != 2'd3);
        beatCnt <= strb.beatIdx + 2'd1;
      end
    end
  end

endmodule

// File: rtl/qdrw_dpath.sv
module qdrw_dpath
  import qdrw_pkg::*;
#(
  parameter int WIDTH  = 36,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  qdrwStrobe_t               strb,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [WIDTH-1:0]          wrData,
  input  logic [WIDTH/LANE_BITS-1:0] laneWrN,
  input  logic [ADDR_W-1:0]         dbgAddr,
  output logic [WIDTH-1:0]          dbgData,
  output logic                      commitValid
);

  localparam int LANES = WIDTH / LANE_BITS;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int STAGE = BEATS - 1;

  logic [ADDR_W-1:0] pendAddr;
  logic [ADDR_W-1:0] burstAddr;
  logic [ADDR_W-1:0] cmtAddr;
  logic [WIDTH-1:0]  stgData [STAGE];
  logic [LANES-1:0]  stgMask [STAGE];
  logic [WIDTH-1:0]  cmtData [BEATS];
  logic [LANES-1:0]  cmtMask [BEATS];
  logic [WIDTH-1:0]  mem     [DEPTH];

  logic [ADDR_W-1:0] beatAddr [BEATS];
  logic [WIDTH-1:0]  merged   [BEATS];

  // Address capture: pending command, then the burst in flight.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr  <= '0;
      burstAddr <= '0;
    end else begin
      if (strb.takeAddr)   pendAddr  <= wrAddr;
      if (strb.startBurst) burstAddr <= pendAddr;
    end
  end

  // Beat staging for beats 0..2.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGE; s++) begin
        stgData[s] <= '0;
        stgMask[s] <= '0;
      end
    end else if (strb.takeBeat && (strb.beatIdx != 2'd3)) begin
      stgData[strb.beatIdx] <= wrData;
      stgMask[strb.beatIdx] <= ~laneWrN;
    end
  end

  // Commit stage: the full burst, written into the array on the next edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitValid <= 1'b0;
      cmtAddr     <= '0;
      for (int b = 0; b < BEATS; b++) begin
        cmtData[b] <= '0;
        cmtMask[b] <= '0;
      end
    end else begin
      commitValid <= strb.loadCommit;
      if (strb.loadCommit) begin
        cmtAddr <= burstAddr;
        for (int b = 0; b < STAGE; b++) begin
          cmtData[b] <= stgData[b];
          cmtMask[b] <= stgMask[b];
        end
        cmtData[STAGE] <= wrData;
        cmtMask[STAGE] <= ~laneWrN;
      end
    end
  end

  // Per-beat word address and lane merge against the current contents.
  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign beatAddr[b] = {cmtAddr[ADDR_W-1:2], cmtAddr[1:0] + 2'(b)};
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[b][l*LANE_BITS +: LANE_BITS] =
        cmtMask[b][l] ? cmtData[b][l*LANE_BITS +: LANE_BITS]
                      : mem[beatAddr[b]][l*LANE_BITS +: LANE_BITS];
    end
  end

  // Array: the four beat addresses of one burst are always distinct.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (commitValid) begin
      for (int b = 0; b < BEATS; b++) mem[beatAddr[b]] <= merged[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dbgData <= '0;
    else       dbgData <= mem[dbgAddr];
  end

endmodule

// File: rtl/qdr_b4_write.sv
module qdr_b4_write
  import qdrw_pkg::*;
#(
  parameter int WIDTH  = 36,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      kEdge,
  input  logic                      wrSelN,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [WIDTH-1:0]          wrData,
  input  logic [WIDTH/LANE_BITS-1:0] laneWrN,
  input  logic [ADDR_W-1:0]         dbgAddr,
  output logic [WIDTH-1:0]          dbgData,
  output logic                      protoErr
);

  qdrwStrobe_t strb;
  logic        commitValid;

  qdrw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .kEdge    (kEdge),
    .wrSelN   (wrSelN),
    .strb     (strb),
    .protoErr (protoErr)
  );

  qdrw_dpath #(
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .laneWrN     (laneWrN),
    .dbgAddr     (dbgAddr),
    .dbgData     (dbgData),
    .commitValid (commitValid)
  );

endmodule

// File: rtl/qdr_b4_write_chk.sv
module qdr_b4_write_chk
  import qdrw_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        kEdge,
  input logic        wrSelN,
  input logic        protoErr,
  input qdrwStrobe_t strb,
  input logic        commitValid
);

  // R7: an error pulse needs a command on the K edge before it
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(kEdge && !wrSelN));

  // R7: the rejected command was not taken
  p_err_dropped_r7: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(!strb.takeAddr));

  // R3: beat 0 is taken only on a K edge
  p_beat0_on_k_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeBeat && strb.beatIdx == 2'd0) |-> kEdge);

  // R3: beats follow on consecutive edges in order
  p_beat_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeBeat && strb.beatIdx != 2'd3) |=>
      (strb.takeBeat && strb.beatIdx == $past(strb.beatIdx) + 2'd1));

  // R8: the array update comes one edge after the last beat
  p_commit_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCommit |=> commitValid);

  // R8: a commit lasts a single edge
  p_commit_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> !commitValid);

endmodule

bind qdr_b4_write qdr_b4_write_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .kEdge       (kEdge),
  .wrSelN      (wrSelN),
  .protoErr    (protoErr),
  .strb        (strb),
  .commitValid (commitValid)
);

// File: tb/qdr_b4_write_tb.sv
`timescale 1ns/1ps
module qdr_b4_write_tb;

  localparam int W  = 36;
  localparam int AW = 4;
  localparam int L  = W / 9;
  localparam int D  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          kEdge;
  logic          wrSelN;
  logic [AW-1:0] wrAddr;
  logic [W-1:0]  wrData;
  logic [L-1:0]  laneWrN;
  logic [AW-1:0] dbgAddr;
  logic [W-1:0]  dbgData;
  logic          protoErr;

  qdr_b4_write #(.WIDTH(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .kEdge(kEdge), .wrSelN(wrSelN),
    .wrAddr(wrAddr), .wrData(wrData), .laneWrN(laneWrN),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .protoErr(protoErr)
  );

  always #2.5 clk = ~clk;

  int   nChk = 0;
  int   nBad = 0;
  int   strayErr = 0;
  bit   errExpected = 1'b0;
  bit   done = 1'b0;
  logic kNext;

  logic [W-1:0]  refMem [D];
  logic [AW-1:0] cBase [4];
  logic [W-1:0]  cD [4][4];
  logic [L-1:0]  cM [4][4];

  function automatic logic [W-1:0] rnd();
    return W'({$urandom(), $urandom()});
  endfunction

  function automatic logic [AW-1:0] wordOf(logic [AW-1:0] base, int i);
    return {base[AW-1:2], base[1:0] + 2'(i)};
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One fast edge. Inputs are set away from the edge, outputs sampled 1 ns after.
  task automatic step(logic sel, logic [AW-1:0] a, logic [W-1:0] d, logic [L-1:0] bw);
    kEdge   = kNext;
    wrSelN  = sel;
    wrAddr  = a;
    wrData  = d;
    laneWrN = bw;
    @(posedge clk);
    #1;
    kNext = ~kNext;
    if (protoErr && !errExpected) strayErr++;
  endtask

  // Idle edge with noise; wrSelN may be low on complement edges (R2, R4).
  task automatic idle();
    step(kNext ? 1'b1 : 1'($urandom()), AW'($urandom()), rnd(), L'($urandom()));
  endtask

  task automatic alignK();
    if (!kNext) idle();
  endtask

  task automatic applyBurst(int k);
    for (int i = 0; i < 4; i++)
      for (int l = 0; l < L; l++)
        if (!cM[k][i][l]) refMem[wordOf(cBase[k], i)][l*9 +: 9] = cD[k][i][l*9 +: 9];
  endtask

  task automatic checkAll(string tag);
    for (int a = 0; a < D; a++) begin
      dbgAddr = AW'(a);
      idle();
      check(tag, dbgData, refMem[a]);
    end
  endtask

  // A chain of n bursts, each next command on the beat-2 edge (R6).
  task automatic runChain(int n, bit injErr, logic [AW-1:0] errAddr);
    logic [AW-1:0] probe;
    logic [W-1:0]  oldVal;
    alignK();
    step(1'b0, cBase[0], rnd(), '0);
    idle();
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 4; i++) begin
        logic          sel;
        logic [AW-1:0] a;
        sel = 1'b1;
        a   = AW'($urandom());
        if (i == 1 || i == 3) sel = 1'($urandom());
        if (i == 2 && k < n - 1) begin
          sel = 1'b0;
          a   = cBase[k+1];
        end
        if (i == 0 && k == 0 && injErr) begin
          sel = 1'b0;
          a   = errAddr;
          errExpected = 1'b1;
        end
        step(sel, a, cD[k][i], cM[k][i]);
        if (injErr && k == 0 && i == 0) begin
          check("R7 error pulse", W'(protoErr), W'(1));
          errExpected = 1'b0;
        end
        if (injErr && k == 0 && i == 1)
          check("R7 error pulse width", W'(protoErr), W'(0));
      end
    end
    for (int k = 0; k < n - 1; k++) applyBurst(k);
    probe  = wordOf(cBase[n-1], 0);
    oldVal = refMem[probe];
    dbgAddr = probe;
    idle();
    check("R8 read on commit edge is old", dbgData, oldVal);
    applyBurst(n - 1);
    idle();
    check("R8 read after commit is new", dbgData, refMem[probe]);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < D; a++) refMem[a] = '0;
    rstN = 1'b0; kEdge = 1'b0; wrSelN = 1'b1; wrAddr = '0;
    wrData = '0; laneWrN = '1; dbgAddr = '0;
    kNext = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    rstN = 1'b1;

    // R1: reset state
    check("R1 protoErr after reset", W'(protoErr), W'(0));
    checkAll("R1 array after reset");

    // R2/R4: noise with no accepted command leaves the array alone
    repeat (40) idle();
    checkAll("R4 noise ignored, R2 complement-edge select");

    // R3: single burst whose base wraps inside its group (words 6,7,4,5)
    cBase[0] = 4'd6;
    for (int i = 0; i < 4; i++) begin
      cD[0][i] = rnd();
      cM[0][i] = '0;
    end
    runChain(1, 1'b0, '0);
    checkAll("R3 beat order and wrap");

    // R5: every base, every lane-mask pattern per beat
    for (int b = 0; b < D; b++) begin
      cBase[0] = AW'(b);
      for (int i = 0; i < 4; i++) begin
        cD[0][i] = rnd();
        cM[0][i] = L'(b * 4 + i + b / 4);
      end
      runChain(1, 1'b0, '0);
      repeat ($urandom_range(0, 3)) idle();
      checkAll("R5 lane masks");
    end

    // R6: back-to-back chain with overlapping groups
    cBase[0] = 4'd1; cBase[1] = 4'd3; cBase[2] = 4'd2; cBase[3] = 4'd9;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 4; i++) begin
        cD[k][i] = rnd();
        cM[k][i] = L'($urandom());
      end
    runChain(4, 1'b0, '0);
    checkAll("R6 back-to-back");

    // R7: command on the first-beat edge is rejected
    cBase[0] = 4'd0;
    for (int i = 0; i < 4; i++) begin
      cD[0][i] = rnd();
      cM[0][i] = '0;
    end
    runChain(1, 1'b1, 4'd8);
    repeat (4) idle();
    checkAll("R7 rejected command writes nothing");

    // Random chains with random masks and gaps
    for (int t = 0; t < 30; t++) begin
      int n;
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) begin
        cBase[k] = AW'($urandom());
        for (int i = 0; i < 4; i++) begin
          cD[k][i] = rnd();
          cM[k][i] = L'($urandom());
        end
      end
      runChain(n, 1'b0, '0);
      repeat ($urandom_range(0, 5)) idle();
      if (t % 5 == 4) checkAll("R3 R5 R6 random bursts");
    end
    checkAll("R3 R5 R6 final sweep");

    check("R7 no spurious error pulse", W'(strayErr), W'(0));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule